// File: doc/BRIEF.md
# Display Frame-Base and Panel Power Controller

This block is the register-side control of a simple LCD controller. The host writes a frame buffer start address into a shadow register. When the timing generator pulses its frame-start strobe, the shadow value is copied into the active scan address that the pixel fetch engine reads. A scan address never changes in the middle of a frame. When a newly written address is taken into use at a frame boundary, a base-update interrupt status bit is set. The host can mask that bit and clear it through its register port.

The block also runs the panel power sequence. On power-up it asserts the panel logic enable at once. It asserts panel power only after a settling window of `SETTLE_CYCLES` clock cycles. The default of 1,000,000 cycles is about 20 ms at 50 MHz. On power-down it removes panel power at once, holds logic enable for the same window, and then clears both bits.

The register port is a single-cycle write strobe with a combinational read. It uses five word addresses: base, control, interrupt enable, masked status and interrupt clear.

Top module: `dfb_ctrl`

## Requirements
- R1: After reset, the active scan address, panel logic enable, panel power and `irq` are all 0, and every register reads as 0.
- R2: A write to address 0 stores the data with bits [1:0] forced to 0, and address 0 reads back that aligned value.
- R3: `scan_base` changes only on a cycle with `frame_start` high. On that cycle it loads the shadow value held before the edge.
- R4: Status bit 0 is set on a `frame_start` cycle only if address 0 was written since the previous `frame_start`. A `frame_start` with no new write leaves the status unchanged.
- R5: Reading address 3 returns the raw status ANDed with the enable register (address 2, bit 0). `irq` is the OR of those masked bits and stays high until they clear.
- R6: A write to address 4 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. A status set in the same cycle takes priority over the clear.
- R7: A control write (address 1) of bit0=1 (logic) and bit1=1 (power), with the panel off, raises `panel_logic_en` on the next cycle. It raises `panel_power_en` exactly `SETTLE_CYCLES` cycles later.
- R8: A control write with bit1=1 and bit0=0, with the panel off, starts the same sequence as R7: logic enable first and power after the settling window.
- R9: A control write of 0 while powered drops `panel_power_en` on the next cycle. `panel_logic_en` stays high for `SETTLE_CYCLES` cycles and then falls.
- R10: Control writes made during the power-down settling window have no effect. The panel ends fully off.
- R11: Address 1 reads bit0 = current logic enable and bit1 = current panel power.
- R12: With logic enabled, power off and settling complete, a control write with bit1=1 raises `panel_power_en` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_start | input | 1 | One-cycle frame-start strobe from the timing generator |
| scan_base | output | 32 | Active scan start address |
| irq | output | 1 | Level interrupt, OR of masked status |
| panel_logic_en | output | 1 | Panel logic enable |
| panel_power_en | output | 1 | Panel power enable |

## Verification
The address path is driven with a fixed-seed random mix of base writes, frame strobes, enable changes and clear writes. This shows whether the active address tracks the shadow only at frame boundaries, and whether the status separates a fresh write from a repeated frame. Directed cases cover a base write in the same cycle as a frame strobe and a clear in the same cycle as a set. The power sequencer is tried with a full request, a power-only request, a late power request after settling, and power-down with writes during the settling window. Cycle counts distinguish an on-time edge from one a cycle early or late.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
    localparam int REG_AW     = 3;
    localparam int ALIGN_BITS = 2;
    localparam int NUM_IRQ    = 1;

    typedef enum logic [REG_AW-1:0] {
        RA_BASE  = 3'd0,
        RA_CTRL  = 3'd1,
        RA_IEN   = 3'd2,
        RA_MSTAT = 3'd3,
        RA_ICLR  = 3'd4
    } reg_addr_e;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_WARM,
        PS_READY,
        PS_ON,
        PS_COOL
    } pwr_state_e;

    typedef struct packed {
        logic power;
        logic logic_en;
    } ctrl_bits_t;

    function automatic ctrl_bits_t state_bits(pwr_state_e s);
        ctrl_bits_t b;
        b.logic_en = (s != PS_OFF);
        b.power    = (s == PS_ON);
        return b;
    endfunction
endpackage

// File: rtl/dfb_base_shadow.sv
module dfb_base_shadow #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          frame_start_i,
    output logic [AW-1:0] shadow_o,
    output logic [AW-1:0] active_o,
    output logic          update_o
);
    import dfb_pkg::*;

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_o <= '0;
            active_o <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (wr_i)
                shadow_o <= {wdata_i[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            if (frame_start_i)
                active_o <= shadow_o;
            if (wr_i)
                pend_q <= 1'b1;
            else if (frame_start_i)
                pend_q <= 1'b0;
        end
    end

    assign update_o = frame_start_i & pend_q;

    assert_scan_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_start_i |=> $stable(active_o));
    assert_scan_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (shadow_o[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/dfb_irq_unit.sv
module dfb_irq_unit #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] clr_mask_i,
    input  logic            ien_wr_i,
    input  logic [NSRC-1:0] ien_wdata_i,
    output logic [NSRC-1:0] ien_o,
    output logic [NSRC-1:0] mstat_o,
    output logic            irq_o
);
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] clr_eff;

    assign clr_eff = clr_wr_i ? clr_mask_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            ien_o <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_eff) | set_i;
            if (ien_wr_i)
                ien_o <= ien_wdata_i;
        end
    end

    assign mstat_o = raw_q & ien_o;
    assign irq_o   = |mstat_o;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_set_source_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(raw_q[i]) |-> $past(set_i[i]));
        assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
            (clr_eff[i] && !set_i[i]) |=> !raw_q[i]);
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> raw_q[i]);
    end
endmodule

// File: rtl/dfb_power_seq.sv
module dfb_power_seq #(
    parameter int SETTLE_CYCLES = 1000000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  dfb_pkg::ctrl_bits_t req_i,
    output dfb_pkg::ctrl_bits_t stat_o
);
    import dfb_pkg::*;

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

    pwr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic pend_q, pend_d;
    logic expired;

    assign expired = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        pend_d  = pend_q;
        case (state_q)
            PS_OFF: begin
                if (wr_i && (req_i.logic_en || req_i.power)) begin
                    state_d = PS_WARM;
                    cnt_d   = LOAD;
                    pend_d  = req_i.power;
                end
            end
            PS_WARM: begin
                if (wr_i)
                    pend_d = req_i.power;
                if (expired)
                    state_d = (wr_i ? req_i.power : pend_q) ? PS_ON : PS_READY;
            end
            PS_READY: begin
                if (wr_i) begin
                    if (req_i.power)
                        state_d = PS_ON;
                    else if (!req_i.logic_en) begin
                        state_d = PS_COOL;
                        cnt_d   = LOAD;
                    end
                end
            end
            PS_ON: begin
                if (wr_i && !req_i.power) begin
                    if (req_i.logic_en)
                        state_d = PS_READY;
                    else begin
                        state_d = PS_COOL;
                        cnt_d   = LOAD;
                    end
                end
            end
            PS_COOL: begin
                if (expired)
                    state_d = PS_OFF;
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_OFF;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    assign stat_o = state_bits(state_q);

    assert_power_after_logic_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_o.power) |-> $past(stat_o.logic_en));
    assert_logic_after_power_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_o.logic_en) |-> $past(!stat_o.power));
    assert_cool_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_COOL) |=> (state_q == PS_COOL || state_q == PS_OFF));
    assert_warm_no_power_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WARM && !expired) |=> !stat_o.power);
endmodule

// File: rtl/dfb_ctrl.sv
module dfb_ctrl #(
    parameter int AW            = 32,
    parameter int SETTLE_CYCLES = 1000000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic [dfb_pkg::REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]              reg_wdata,
    output logic [AW-1:0]              reg_rdata,
    input  logic                       frame_start,
    output logic [AW-1:0]              scan_base,
    output logic                       irq,
    output logic                       panel_logic_en,
    output logic                       panel_power_en
);
    import dfb_pkg::*;

    logic [AW-1:0]      shadow;
    logic               upd;
    logic [NUM_IRQ-1:0] ien, mstat;
    ctrl_bits_t         pstat, preq;

    logic wr_base, wr_ctrl, wr_ien, wr_clr;
    assign wr_base = reg_wr && (reg_addr == RA_BASE);
    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_ien  = reg_wr && (reg_addr == RA_IEN);
    assign wr_clr  = reg_wr && (reg_addr == RA_ICLR);
    assign preq    = ctrl_bits_t'(reg_wdata[1:0]);

    dfb_base_shadow #(.AW(AW)) u_base (
        .clk(clk), .rst(rst), .wr_i(wr_base), .wdata_i(reg_wdata),
        .frame_start_i(frame_start), .shadow_o(shadow),
        .active_o(scan_base), .update_o(upd)
    );

    dfb_irq_unit #(.NSRC(NUM_IRQ)) u_irq (
        .clk(clk), .rst(rst), .set_i(upd), .clr_wr_i(wr_clr),
        .clr_mask_i(reg_wdata[NUM_IRQ-1:0]), .ien_wr_i(wr_ien),
        .ien_wdata_i(reg_wdata[NUM_IRQ-1:0]), .ien_o(ien),
        .mstat_o(mstat), .irq_o(irq)
    );

    dfb_power_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pwr (
        .clk(clk), .rst(rst), .wr_i(wr_ctrl), .req_i(preq), .stat_o(pstat)
    );

    assign panel_logic_en = pstat.logic_en;
    assign panel_power_en = pstat.power;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BASE:  reg_rdata = shadow;
            RA_CTRL:  reg_rdata[1:0] = pstat;
            RA_IEN:   reg_rdata[NUM_IRQ-1:0] = ien;
            RA_MSTAT: reg_rdata[NUM_IRQ-1:0] = mstat;
            default:  reg_rdata = '0;
        endcase
    end

    assert_irq_needs_update_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(upd) || $past(wr_ien)));
endmodule

// File: tb/dfb_ctrl_tb_top.sv
module dfb_ctrl_tb_top;
    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic [31:0] scan_base;
    logic        irq, panel_logic_en, panel_power_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_shadow = '0, m_active = '0;
    logic        m_pend = 1'b0, m_raw = 1'b0, m_ien = 1'b0;

    always #10 clk = ~clk;

    dfb_ctrl #(.AW(32), .SETTLE_CYCLES(N)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_start(frame_start), .scan_base(scan_base), .irq(irq),
        .panel_logic_en(panel_logic_en), .panel_power_en(panel_power_en)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // one clock cycle: drive at negedge, release at the following negedge
    task automatic step(logic w, logic [2:0] a, logic [31:0] d, logic fs);
        reg_wr = w; reg_addr = a; reg_wdata = d; frame_start = fs;
        @(negedge clk);
        reg_wr = 1'b0; frame_start = 1'b0;
    endtask

    function automatic logic [31:0] align(logic [31:0] d);
        return {d[31:2], 2'b00};
    endfunction

    // reference model of one cycle of the address/interrupt path
    task automatic model(logic w, logic [2:0] a, logic [31:0] d, logic fs);
        logic set;
        set = fs && m_pend;
        if (fs) m_active = m_shadow;
        if (w && a == 3'd0) m_shadow = align(d);
        if (w && a == 3'd0) m_pend = 1'b1;
        else if (fs) m_pend = 1'b0;
        if (w && a == 3'd4 && d[0]) m_raw = 1'b0;
        if (set) m_raw = 1'b1;
        if (w && a == 3'd2) m_ien = d[0];
    endtask

    task automatic op(logic w, logic [2:0] a, logic [31:0] d, logic fs, string req);
        logic [31:0] v;
        step(w, a, d, fs);
        model(w, a, d, fs);
        chk({req, " scan_base"}, scan_base, m_active);
        rd(3'd3, v);
        chk({req, " R5 masked status"}, v, {31'b0, m_raw & m_ien});
        chk({req, " R5 irq"}, {31'b0, irq}, {31'b0, m_raw & m_ien});
        rd(3'd0, v);
        chk({req, " R2 shadow"}, v, m_shadow);
    endtask

    task automatic ctrl_chk(string req, logic le, logic pw);
        logic [31:0] v;
        chk({req, " logic_en"}, {31'b0, panel_logic_en}, {31'b0, le});
        chk({req, " power_en"}, {31'b0, panel_power_en}, {31'b0, pw});
        rd(3'd1, v);
        chk({req, " R11 ctrl read"}, v, {30'b0, pw, le});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 scan_base", scan_base, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        ctrl_chk("R1", 1'b0, 1'b0);
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], v);
            chk("R1 reg read", v, 32'h0);
        end

        // directed address/interrupt cases
        op(1'b1, 3'd2, 32'h1, 1'b0, "R5 enable");
        op(1'b1, 3'd0, 32'h1234_567F, 1'b0, "R2 unaligned write");
        op(1'b0, 3'd0, 32'h0, 1'b0, "R3 no strobe hold");
        op(1'b0, 3'd0, 32'h0, 1'b1, "R3 R4 strobe takes base");
        op(1'b0, 3'd0, 32'h0, 1'b1, "R4 repeat strobe");
        op(1'b1, 3'd4, 32'h0, 1'b0, "R6 zero clear no effect");
        op(1'b1, 3'd4, 32'h1, 1'b0, "R6 clear");
        op(1'b0, 3'd0, 32'h0, 1'b1, "R4 strobe without write");
        op(1'b1, 3'd0, 32'hA000_0002, 1'b1, "R3 write with strobe");
        op(1'b0, 3'd0, 32'h0, 1'b1, "R4 later strobe");
        op(1'b1, 3'd2, 32'h0, 1'b0, "R5 mask off");
        op(1'b1, 3'd2, 32'h1, 1'b0, "R5 mask on");
        op(1'b1, 3'd0, 32'h0000_1000, 1'b0, "R2 write");
        op(1'b1, 3'd4, 32'h1, 1'b1, "R6 set beats clear");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int k;
            logic [31:0] d;
            k = $urandom_range(0, 4);
            d = $urandom;
            case (k)
                0: op(1'b1, 3'd0, d, d[5], "R3 rand base");
                1: op(1'b0, 3'd0, 32'h0, 1'b1, "R4 rand strobe");
                2: op(1'b1, 3'd2, d, d[7], "R5 rand ien");
                3: op(1'b1, 3'd4, d, d[9], "R6 rand clear");
                default: op(1'b0, 3'd0, 32'h0, 1'b0, "R3 rand idle");
            endcase
        end

        // R7: full request from off
        step(1'b1, 3'd1, 32'h3, 1'b0);
        ctrl_chk("R7 start", 1'b1, 1'b0);
        repeat (N - 1) @(negedge clk);
        ctrl_chk("R7 before window end", 1'b1, 1'b0);
        @(negedge clk);
        ctrl_chk("R7 powered", 1'b1, 1'b1);

        // R9: power-down
        step(1'b1, 3'd1, 32'h0, 1'b0);
        ctrl_chk("R9 power dropped", 1'b1, 1'b0);
        repeat (N - 1) @(negedge clk);
        ctrl_chk("R9 logic held", 1'b1, 1'b0);
        @(negedge clk);
        ctrl_chk("R9 off", 1'b0, 1'b0);

        // R8: power-only request
        step(1'b1, 3'd1, 32'h2, 1'b0);
        ctrl_chk("R8 start", 1'b1, 1'b0);
        repeat (N - 1) @(negedge clk);
        ctrl_chk("R8 before window end", 1'b1, 1'b0);
        @(negedge clk);
        ctrl_chk("R8 powered", 1'b1, 1'b1);

        // R10: writes during power-down settling ignored
        step(1'b1, 3'd1, 32'h0, 1'b0);
        step(1'b1, 3'd1, 32'h3, 1'b0);
        ctrl_chk("R10 ignored write", 1'b1, 1'b0);
        repeat (N - 2) @(negedge clk);
        ctrl_chk("R10 still settling", 1'b1, 1'b0);
        @(negedge clk);
        ctrl_chk("R10 off", 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        ctrl_chk("R10 stays off", 1'b0, 1'b0);

        // R12: logic only, then late power request
        step(1'b1, 3'd1, 32'h1, 1'b0);
        repeat (N + 2) @(negedge clk);
        ctrl_chk("R12 ready unpowered", 1'b1, 1'b0);
        step(1'b1, 3'd1, 32'h3, 1'b0);
        ctrl_chk("R12 immediate power", 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule